// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block sits between a host register port and a card-side command engine inside an SD host controller. Software loads a 32-bit argument and then writes a 16-bit command word. When the block accepts the word it raises a one-cycle start strobe to the command engine and presents the word and argument. The command word holds the command index in bits 15:8 and a response code in bits 7:0. The block refuses a command word while the command path is still occupied. It also refuses a command that expects a busy response while the data path is still occupied.

When the engine finishes, the block frees the command path and raises a status bit. It also stores the card response, right-aligned, in four 32-bit response registers. Engine errors are collected in a separate error status word. A summary bit shows whether any enabled error is pending. Software clears status bits by writing ones to them. Three reset requests (whole block, command path, data path) each stay visible for a fixed number of cycles and then clear themselves.

Top module: `sd_cmd_issue_unit`

Register map (word addresses on `reg_addr`): 0 argument, 1 command word, 2..5 response words 0..3, 6 present state, 7 interrupt status, 8 error enable, 9 software reset.

## Requirements
- R1: After reset, the present-state word reads with bits 1:0 both zero, the interrupt status word reads zero, and `eng_start` is low.
- R2: Writing the command word while the command path is free gives a one-cycle `eng_start` pulse. `eng_cmd_word` then shows the written word and `eng_arg` shows the argument register. Present-state bit 0 (command inhibit) reads 1 until the engine finishes.
- R3: A command write made while present-state bit 0 is set produces no `eng_start`, and it leaves `eng_cmd_word` and the command register unchanged.
- R4: A command whose code bits 1:0 are both 1 (busy response) is refused while present-state bit 1 (data inhibit) is set. A command without busy is still accepted in that state. An accepted command with code bit 5 (data) or with busy sets data inhibit. A `dat_done` pulse clears data inhibit.
- R5: `eng_done` clears command inhibit and sets status bit 0. With code bits 1:0 = 01 (136-bit), all four response words take `eng_rsp`. With bits 1:0 = 10 or 11 (48-bit), word 0 takes `eng_rsp[31:0]` and words 1..3 read zero. With 00, the responses are unchanged.
- R6: `eng_err` clears command inhibit and ORs `eng_err_code` into the error status (interrupt status bits 31:16). It does not set status bit 0, and it takes precedence over an `eng_done` in the same cycle.
- R7: Interrupt status bit 15 reads 1 exactly when the error status and the error enable register (bits 15:0) share a set bit.
- R8: Writing the interrupt status word clears each bit written with 1 in bits 0, 1, 4, 5 and 31:16. Bits written with 0 keep their value. Bit 15 cannot be cleared by a write.
- R9: Pulses on `dat_done`, `buf_wr_rdy` and `buf_rd_rdy` set status bits 1, 4 and 5 respectively.
- R10: Writing 1 to a software reset bit (bit 0 all, bit 1 command, bit 2 data) makes that bit read 1 for exactly RST_CYCLES cycles before it clears itself. `cmd_path_rst` or `dat_path_rst` is high for the same cycles.
- R11: A command reset clears command inhibit and status bit 0, and leaves data inhibit and bits 1, 4, 5 alone. A data reset clears data inhibit and bits 1, 4, 5, and leaves the command side alone.
- R12: A reset of the whole block returns the argument, command, response, status and error enable registers to zero.
- R13: Present-state bit 16 follows `card_present`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; data appears on `reg_rdata` after the next edge |
| reg_rdata | output | 32 | Registered read data |
| card_present | input | 1 | Card inserted indication |
| eng_start | output | 1 | One-cycle command start strobe |
| eng_cmd_word | output | 16 | Accepted command word |
| eng_arg | output | 32 | Command argument |
| eng_done | input | 1 | Command engine finished |
| eng_err | input | 1 | Command engine failed |
| eng_err_code | input | 16 | Error bits reported with `eng_err` |
| eng_rsp | input | 128 | Response bits, right-aligned |
| dat_done | input | 1 | Data transfer or busy phase finished |
| buf_wr_rdy | input | 1 | Buffer ready for write data |
| buf_rd_rdy | input | 1 | Buffer holds read data |
| cmd_path_rst | output | 1 | Command path reset in progress |
| dat_path_rst | output | 1 | Data path reset in progress |

## Verification
A stuck command inhibit shows up on the next command write as a missing start strobe, and it shows in present-state bit 0 one read later. A wrong response kind decode shows as a mismatched or unzeroed response word on the first read after `eng_done`. Status or summary faults appear in the interrupt status word one read after the event. A miscounted reset length changes the number of cycles the path reset outputs stay high, and that count is measured cycle by cycle.

// File: rtl/sdci_pkg.sv
package sdci_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 16;

  localparam logic [ADDR_W-1:0] A_ARG   = 4'h0;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'h1;
  localparam logic [ADDR_W-1:0] A_RSP0  = 4'h2;
  localparam logic [ADDR_W-1:0] A_STATE = 4'h6;
  localparam logic [ADDR_W-1:0] A_IRQ   = 4'h7;
  localparam logic [ADDR_W-1:0] A_ERREN = 4'h8;
  localparam logic [ADDR_W-1:0] A_SRST  = 4'h9;

  localparam int SRST_N   = 3;
  localparam int SRST_ALL = 0;
  localparam int SRST_CMD = 1;
  localparam int SRST_DAT = 2;

  typedef enum logic [1:0] {RK_NONE, RK_SHORT, RK_LONG} rsp_kind_e;

  function automatic rsp_kind_e rsp_kind(input logic [1:0] code_lo);
    case (code_lo)
      2'b00:   return RK_NONE;
      2'b01:   return RK_LONG;
      default: return RK_SHORT;
    endcase
  endfunction

  function automatic logic wants_busy(input logic [1:0] code_lo);
    return code_lo == 2'b11;
  endfunction
endpackage

// File: rtl/sdci_issue_ctrl.sv
module sdci_issue_ctrl
  import sdci_pkg::*;
(
  input  logic             clk,
  input  logic             wipe,
  input  logic             cmd_clr,
  input  logic             dat_clr,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic             dat_done,
  output logic             cmd_inh,
  output logic             dat_inh,
  output logic             eng_start,
  output logic [CMD_W-1:0] cmd_word,
  output logic             fin_ok,
  output logic             fin_err
);
  logic accept, fin, busy_req, data_req;

  always_comb begin
    busy_req = wants_busy(cmd_wdata[1:0]);
    data_req = cmd_wdata[5] | busy_req;
    accept   = cmd_wr && !cmd_clr && !cmd_inh && !(busy_req && dat_inh);
    fin      = cmd_inh && !cmd_clr && (eng_done || eng_err);
    fin_ok   = fin && !eng_err;
    fin_err  = fin && eng_err;
  end

  always_ff @(posedge clk) begin
    if (wipe) cmd_word <= '0;
    else if (accept) cmd_word <= cmd_wdata;

    if (cmd_clr) begin
      cmd_inh   <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= accept;
      if (accept) cmd_inh <= 1'b1;
      else if (fin) cmd_inh <= 1'b0;
    end

    if (dat_clr) dat_inh <= 1'b0;
    else if (accept && data_req) dat_inh <= 1'b1;
    else if (dat_done) dat_inh <= 1'b0;
  end
endmodule

// File: rtl/sdci_rsp_store.sv
module sdci_rsp_store
  import sdci_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                    clk,
  input  logic                    wipe,
  input  logic                    capture,
  input  rsp_kind_e               kind,
  input  logic [WORDS*DATA_W-1:0] rsp_in,
  output logic [WORDS*DATA_W-1:0] rsp_q
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (wipe) begin
        rsp_q[w*DATA_W +: DATA_W] <= '0;
      end else if (capture) begin
        if (kind == RK_LONG)
          rsp_q[w*DATA_W +: DATA_W] <= rsp_in[w*DATA_W +: DATA_W];
        else if (kind == RK_SHORT)
          rsp_q[w*DATA_W +: DATA_W] <= (w == 0) ? rsp_in[w*DATA_W +: DATA_W] : '0;
      end
    end
  end
endmodule

// File: rtl/sdci_irq_status.sv
module sdci_irq_status #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             wipe,
  input  logic             cmd_rst,
  input  logic             dat_rst,
  input  logic             ev_cc,
  input  logic             ev_err,
  input  logic [ERR_W-1:0] err_code,
  input  logic             ev_td,
  input  logic             ev_wr,
  input  logic             ev_rd,
  input  logic             clr_wr,
  input  logic [15:0]      clr_norm,
  input  logic [ERR_W-1:0] clr_err,
  input  logic [ERR_W-1:0] err_en,
  output logic [15:0]      norm_sts,
  output logic [ERR_W-1:0] err_sts
);
  logic cc_q, td_q, wr_q, rd_q;
  logic [15:0] c;

  assign c = clr_wr ? clr_norm : 16'h0;

  always_ff @(posedge clk) begin
    if (wipe) begin
      cc_q <= 1'b0; td_q <= 1'b0; wr_q <= 1'b0; rd_q <= 1'b0;
      err_sts <= '0;
    end else begin
      cc_q <= cmd_rst ? 1'b0 : ((cc_q & ~c[0]) | ev_cc);
      td_q <= dat_rst ? 1'b0 : ((td_q & ~c[1]) | ev_td);
      wr_q <= dat_rst ? 1'b0 : ((wr_q & ~c[4]) | ev_wr);
      rd_q <= dat_rst ? 1'b0 : ((rd_q & ~c[5]) | ev_rd);
      err_sts <= (err_sts & ~(clr_wr ? clr_err : '0)) | (ev_err ? err_code : '0);
    end
  end

  assign norm_sts = {|(err_sts & err_en), 9'b0, rd_q, wr_q, 2'b0, td_q, cc_q};
endmodule

// File: rtl/sdci_soft_reset.sv
module sdci_soft_reset #(
  parameter int NUM    = 3,
  parameter int CYCLES = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_wr,
  input  logic [NUM-1:0] req_bits,
  output logic [NUM-1:0] active
);
  localparam int CW = $clog2(CYCLES + 1);

  for (genvar i = 0; i < NUM; i++) begin : g_bit
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        active[i] <= 1'b0;
        cnt       <= '0;
      end else if (active[i]) begin
        if (cnt == '0) active[i] <= 1'b0;
        else cnt <= cnt - 1'b1;
      end else if (req_wr && req_bits[i]) begin
        active[i] <= 1'b1;
        cnt       <= CW'(CYCLES - 1);
      end
    end
  end
endmodule

// File: rtl/sd_cmd_issue_unit.sv
module sd_cmd_issue_unit
  import sdci_pkg::*;
#(
  parameter int RSP_WORDS  = 4,
  parameter int ERR_W      = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wr,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic                        reg_rd,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic                        card_present,
  output logic                        eng_start,
  output logic [CMD_W-1:0]            eng_cmd_word,
  output logic [DATA_W-1:0]           eng_arg,
  input  logic                        eng_done,
  input  logic                        eng_err,
  input  logic [ERR_W-1:0]            eng_err_code,
  input  logic [RSP_WORDS*DATA_W-1:0] eng_rsp,
  input  logic                        dat_done,
  input  logic                        buf_wr_rdy,
  input  logic                        buf_rd_rdy,
  output logic                        cmd_path_rst,
  output logic                        dat_path_rst
);
  logic [SRST_N-1:0] srst_act;
  logic wipe, cmd_clr, dat_clr, wr_ok;
  logic cmd_inh, dat_inh, fin_ok, fin_err;
  logic [DATA_W-1:0] arg_q;
  logic [ERR_W-1:0] err_en, err_sts;
  logic [15:0] norm_sts;
  logic [RSP_WORDS*DATA_W-1:0] rsp_q;
  logic [DATA_W-1:0] rd_mux;

  assign wipe    = rst | srst_act[SRST_ALL];
  assign cmd_clr = wipe | srst_act[SRST_CMD];
  assign dat_clr = wipe | srst_act[SRST_DAT];
  assign wr_ok   = reg_wr & ~srst_act[SRST_ALL];

  sdci_soft_reset #(.NUM(SRST_N), .CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst(rst),
    .req_wr(wr_ok && reg_addr == A_SRST),
    .req_bits(reg_wdata[SRST_N-1:0]),
    .active(srst_act)
  );

  sdci_issue_ctrl u_issue (
    .clk(clk), .wipe(wipe), .cmd_clr(cmd_clr), .dat_clr(dat_clr),
    .cmd_wr(wr_ok && reg_addr == A_CMD), .cmd_wdata(reg_wdata[CMD_W-1:0]),
    .eng_done(eng_done), .eng_err(eng_err), .dat_done(dat_done),
    .cmd_inh(cmd_inh), .dat_inh(dat_inh), .eng_start(eng_start),
    .cmd_word(eng_cmd_word), .fin_ok(fin_ok), .fin_err(fin_err)
  );

  sdci_rsp_store #(.WORDS(RSP_WORDS)) u_rsp (
    .clk(clk), .wipe(wipe), .capture(fin_ok),
    .kind(rsp_kind(eng_cmd_word[1:0])), .rsp_in(eng_rsp), .rsp_q(rsp_q)
  );

  sdci_irq_status #(.ERR_W(ERR_W)) u_irq (
    .clk(clk), .wipe(wipe),
    .cmd_rst(srst_act[SRST_CMD]), .dat_rst(srst_act[SRST_DAT]),
    .ev_cc(fin_ok), .ev_err(fin_err), .err_code(eng_err_code),
    .ev_td(dat_done & ~dat_clr), .ev_wr(buf_wr_rdy & ~dat_clr),
    .ev_rd(buf_rd_rdy & ~dat_clr),
    .clr_wr(wr_ok && reg_addr == A_IRQ),
    .clr_norm(reg_wdata[15:0]), .clr_err(reg_wdata[16 +: ERR_W]),
    .err_en(err_en), .norm_sts(norm_sts), .err_sts(err_sts)
  );

  always_ff @(posedge clk) begin
    if (wipe) begin
      arg_q  <= '0;
      err_en <= '0;
    end else if (wr_ok) begin
      if (reg_addr == A_ARG) arg_q <= reg_wdata;
      if (reg_addr == A_ERREN) err_en <= reg_wdata[ERR_W-1:0];
    end
  end
  assign eng_arg = arg_q;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_ARG:   rd_mux = arg_q;
      A_CMD:   rd_mux = {{(DATA_W-CMD_W){1'b0}}, eng_cmd_word};
      A_STATE: rd_mux = {15'b0, card_present, 14'b0, dat_inh, cmd_inh};
      A_IRQ:   rd_mux = {err_sts, norm_sts};
      A_ERREN: rd_mux = {{(DATA_W-ERR_W){1'b0}}, err_en};
      A_SRST:  rd_mux = {{(DATA_W-SRST_N){1'b0}}, srst_act};
      default: begin
        for (int w = 0; w < RSP_WORDS; w++)
          if (reg_addr == A_RSP0 + ADDR_W'(w)) rd_mux = rsp_q[w*DATA_W +: DATA_W];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign cmd_path_rst = srst_act[SRST_ALL] | srst_act[SRST_CMD];
  assign dat_path_rst = srst_act[SRST_ALL] | srst_act[SRST_DAT];
endmodule

// File: rtl/sdci_chk.sv
module sdci_chk
  import sdci_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              eng_start,
  input logic              cmd_inh,
  input logic              cmd_clr,
  input logic              eng_done,
  input logic              eng_err,
  input logic              cc_bit,
  input logic              cmd_srst
);
  localparam int CW = $clog2(RST_CYCLES + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (cmd_srst) run_cnt <= run_cnt + 1'b1;
    else run_cnt <= '0;
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(reg_wr && reg_addr == A_CMD));
  // R3
  inhibit_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CMD && cmd_inh) |=> !eng_start);
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_inh && eng_done && !eng_err && !cmd_clr) |=> (!cmd_inh && cc_bit));
  // R6
  err_no_cc_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_inh && eng_err && !cmd_clr && !cc_bit) |=> (!cmd_inh && !cc_bit));
  // R10
  srst_len_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_srst |-> (run_cnt < CW'(RST_CYCLES)));
endmodule

bind sd_cmd_issue_unit sdci_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .eng_start(eng_start), .cmd_inh(cmd_inh), .cmd_clr(cmd_clr),
  .eng_done(eng_done), .eng_err(eng_err), .cc_bit(norm_sts[0]),
  .cmd_srst(srst_act[1])
);

// File: tb/tb_sd_cmd_issue_unit.sv
module tb_sd_cmd_issue_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 4;

  logic clk = 0, rst = 1;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic card_present = 0;
  logic eng_start, eng_done = 0, eng_err = 0;
  logic [15:0] eng_cmd_word, eng_err_code = 0;
  logic [31:0] eng_arg;
  logic [127:0] eng_rsp = 0;
  logic dat_done = 0, buf_wr_rdy = 0, buf_rd_rdy = 0;
  logic cmd_path_rst, dat_path_rst;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_issue_unit #(.RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .card_present(card_present), .eng_start(eng_start),
    .eng_cmd_word(eng_cmd_word), .eng_arg(eng_arg), .eng_done(eng_done),
    .eng_err(eng_err), .eng_err_code(eng_err_code), .eng_rsp(eng_rsp),
    .dat_done(dat_done), .buf_wr_rdy(buf_wr_rdy), .buf_rd_rdy(buf_rd_rdy),
    .cmd_path_rst(cmd_path_rst), .dat_path_rst(dat_path_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic engine(input logic done, input logic err, input logic [15:0] code);
    @(negedge clk); eng_done = done; eng_err = err; eng_err_code = code;
    @(negedge clk); eng_done = 0; eng_err = 0; eng_err_code = 0;
  endtask

  task automatic pulse_dat(input int which);
    @(negedge clk);
    if (which == 0) dat_done = 1; else if (which == 1) buf_wr_rdy = 1; else buf_rd_rdy = 1;
    @(negedge clk); dat_done = 0; buf_wr_rdy = 0; buf_rd_rdy = 0;
  endtask

  task automatic t_reset_state;
    card_present = 1;
    chk("R1 start low", 32'(eng_start), 0);
    rd_chk("R1/R13 state", 4'h6, 32'h0001_0000);
    rd_chk("R1 irq", 4'h7, 0);
    card_present = 0;
    rd_chk("R13 card gone", 4'h6, 0);
    card_present = 1;
  endtask

  task automatic t_issue_short;
    wr(4'h0, 32'hDEAD_BEEF);
    wr(4'h1, 32'h0000_0D1A);
    chk("R2 start", 32'(eng_start), 1);
    chk("R2 word", 32'(eng_cmd_word), 32'h0D1A);
    chk("R2 arg", eng_arg, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R2 one pulse", 32'(eng_start), 0);
    rd_chk("R2 inhibit", 4'h6, 32'h0001_0001);
    wr(4'h1, 32'h0000_0200);
    chk("R3 no start", 32'(eng_start), 0);
    chk("R3 word kept", 32'(eng_cmd_word), 32'h0D1A);
    eng_rsp = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    engine(1, 0, 0);
    rd_chk("R5 inhibit clear", 4'h6, 32'h0001_0000);
    rd_chk("R5 cc bit", 4'h7, 32'h0000_0001);
    rd_chk("R5 rsp0 short", 4'h2, 32'h1111_1111);
    rd_chk("R5 rsp1 zero", 4'h3, 0);
    wr(4'h7, 0);
    rd_chk("R8 zero keeps", 4'h7, 32'h1);
    wr(4'h7, 1);
    rd_chk("R8 one clears", 4'h7, 0);
  endtask

  task automatic t_issue_long;
    wr(4'h1, 32'h0000_0209);
    eng_rsp = {32'hA3A3_A3A3, 32'hA2A2_A2A2, 32'hA1A1_A1A1, 32'hA0A0_A0A0};
    engine(1, 0, 0);
    rd_chk("R5 long w0", 4'h2, 32'hA0A0_A0A0);
    rd_chk("R5 long w3", 4'h5, 32'hA3A3_A3A3);
    wr(4'h1, 32'h0000_0000);
    eng_rsp = '0;
    engine(1, 0, 0);
    rd_chk("R5 none keeps w1", 4'h3, 32'hA1A1_A1A1);
    wr(4'h7, 1);
  endtask

  task automatic t_data;
    wr(4'h1, 32'h0000_113A);
    rd_chk("R4 dat inhibit set", 4'h6, 32'h0001_0003);
    engine(1, 0, 0);
    rd_chk("R4 dat stays", 4'h6, 32'h0001_0002);
    wr(4'h1, 32'h0000_071B);
    chk("R4 busy refused", 32'(eng_start), 0);
    chk("R4 busy word kept", 32'(eng_cmd_word), 32'h113A);
    wr(4'h1, 32'h0000_0D1A);
    chk("R4 plain accepted", 32'(eng_start), 1);
    engine(1, 0, 0);
    pulse_dat(0);
    rd_chk("R4 dat_done clears", 4'h6, 32'h0001_0000);
    pulse_dat(1);
    pulse_dat(2);
    rd_chk("R9 bits", 4'h7, 32'h0000_0033);
    wr(4'h7, 32'h0000_0033);
    rd_chk("R8 multi clear", 4'h7, 0);
  endtask

  task automatic t_error;
    wr(4'h8, 32'h0000_0002);
    wr(4'h1, 32'h0000_0D1A);
    engine(1, 1, 16'h0001);
    rd_chk("R6 err no cc", 4'h7, 32'h0001_0000);
    rd_chk("R6 inhibit clear", 4'h6, 32'h0001_0000);
    wr(4'h8, 32'h0000_0001);
    rd_chk("R7 summary", 4'h7, 32'h0001_8000);
    wr(4'h7, 32'h0000_8000);
    rd_chk("R8 summary not writable", 4'h7, 32'h0001_8000);
    wr(4'h7, 32'h0001_0000);
    rd_chk("R8 err clear", 4'h7, 0);
  endtask

  task automatic t_srst;
    int n;
    wr(4'h1, 32'h0000_113A);
    pulse_dat(2);
    wr(4'h9, 32'h2);
    n = 0;
    while (cmd_path_rst && n < 50) begin n++; @(negedge clk); end
    chk("R10 cmd reset length", 32'(n), RSTC);
    rd_chk("R10 self clear", 4'h9, 0);
    rd_chk("R11 cmd reset state", 4'h6, 32'h0001_0002);
    rd_chk("R11 data bits kept", 4'h7, 32'h0000_0020);
    wr(4'h9, 32'h4);
    rd_chk("R10 dat bit visible", 4'h9, 32'h4);
    chk("R10 dat_path_rst", 32'(dat_path_rst), 1);
    repeat (RSTC + 2) @(negedge clk);
    rd_chk("R11 dat reset state", 4'h6, 32'h0001_0000);
    rd_chk("R11 data bits cleared", 4'h7, 0);
  endtask

  task automatic t_all;
    wr(4'h0, 32'h1234_5678);
    wr(4'h8, 32'h0000_FFFF);
    wr(4'h1, 32'h0000_0D1A);
    eng_rsp = 128'h55;
    engine(1, 0, 0);
    wr(4'h9, 32'h1);
    repeat (RSTC + 2) @(negedge clk);
    rd_chk("R12 arg", 4'h0, 0);
    rd_chk("R12 cmd", 4'h1, 0);
    rd_chk("R12 rsp0", 4'h2, 0);
    rd_chk("R12 irq", 4'h7, 0);
    rd_chk("R12 erren", 4'h8, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    t_issue_short();
    t_issue_long();
    t_data();
    t_error();
    t_srst();
    t_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule